// File: doc/BRIEF.md
# Two-Stage Virtual-Channel Wormhole Router

This block is a compact wormhole router with `NP` input ports and `NP` output ports. Each input port holds `NV` virtual-channel queues, and each output port offers `NV` output virtual channels. Each output virtual channel has its own credit counter, and the downstream side returns credits to it. Flits move through two pipeline stages.

In the first stage, a head flit at the front of an idle queue takes its output port from its destination field. In the same cycle it competes for a free output virtual channel. In the second stage, every flit whose queue holds an allocation competes for the switch. The winning flit is dequeued and crosses the crossbar into a registered output, and link traversal follows from there.

Body and tail flits reuse the allocation stored with their queue. A departing tail flit releases the output virtual channel and returns its queue to idle. Because of this, a packet that follows immediately on the same queue sees a one-cycle bubble. Packets on different queues of one port advance independently of each other. An upstream stage feeds one flit per input port per cycle, tagged with its input virtual channel. A downstream stage returns one credit pulse per consumed flit for each output virtual channel.

Top module: `vc_router`

## Requirements
- R1: After reset, no output is valid, every output virtual channel is free, and every credit counter holds `CRED`.
- R2: Flit layout is type in bits [FW-1:FW-2] (00 body, 01 tail, 10 head, 11 single-flit packet), destination port in the next `PORT_W` bits, and payload in the low `PW` bits. An uncontended head written in cycle c leaves on output port = destination, valid in cycle c+3.
- R3: Only the flit at the front of a queue may compete for the switch. Flits of one packet leave in order, and a body flit that directly follows an uncontended head leaves one cycle after it.
- R4: Body and tail flits leave on the same output port and output virtual channel that their head obtained.
- R5: When a tail leaves, its output virtual channel is freed and its queue returns to idle. The next head on that queue leaves two cycles after that tail, which leaves one empty cycle between them.
- R6: The two queues of one port progress independently. A head on the second queue is allocated and sent while the first queue is still sending its packet.
- R7: The output virtual channel granted is the lowest-numbered free one at the target port, whatever the input virtual channel.
- R8: A head waits while every output virtual channel at its target port is held. At most `NV` packets are open on one output port at once.
- R9: A flit is never sent to an output virtual channel with zero credits. A credit returned in cycle k lets a waiting flit be valid at the output in cycle k+2.
- R10: Each cycle, at most one flit leaves each input port and at most one flit enters each output port.
- R11: A single-flit packet both acquires and releases an output virtual channel, so a second one right behind it on the same queue receives the same output virtual channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NP | Flit present on each input port |
| in_vc | input | NP*OVC_W | Input virtual channel of each incoming flit |
| in_flit | input | NP*FW | Incoming flit per input port |
| credit_ret | input | NP*NV | Credit pulse per output virtual channel (port-major) |
| out_valid | output | NP | Registered flit valid per output port |
| out_vc | output | NP*OVC_W | Output virtual channel of each outgoing flit |
| out_flit | output | NP*FW | Registered outgoing flit per output port |

## Verification
The assertions take three things for granted about the inputs. Upstream never writes into a full queue. Credits are returned only for flits that actually left, so no counter is pushed past `CRED`. Every packet begins with a head or single-flit type and ends with a tail.

The bench keeps to this in three ways. It never has more flits outstanding on a queue than the queue depth. It returns exactly one credit per observed output flit, or it returns them by hand in counted numbers that restore the full count. It always builds packets as head, bodies, tail, or as a single flit.

// File: rtl/vcr_pkg.sv
package vcr_pkg;
  typedef enum logic [1:0] {
    FK_BODY = 2'b00,
    FK_TAIL = 2'b01,
    FK_HEAD = 2'b10,
    FK_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic kind_opens(logic [1:0] k);
    return k[1];
  endfunction

  function automatic logic kind_closes(logic [1:0] k);
    return k[0];
  endfunction
endpackage

// File: rtl/vcr_rr_arb.sv
module vcr_rr_arb #(
  parameter int N = 2,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] last_q, last_d, cand, win;
  logic          hit;

  always_comb begin
    gnt  = '0;
    hit  = 1'b0;
    win  = '0;
    cand = '0;
    for (int i = 0; i < N; i++) begin
      cand = IW'((int'(last_q) + 1 + i) % N);
      if (!hit && req[cand]) begin
        hit = 1'b1;
        win = cand;
      end
    end
    if (hit) gnt[win] = 1'b1;
    last_d = (adv && hit) ? win : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  // R10: a grant is one-hot and only goes to a requester
  assert_gnt_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));
endmodule

// File: rtl/vcr_ivc.sv
module vcr_ivc #(
  parameter int DEPTH  = 4,
  parameter int FW     = 11,
  parameter int PORT_W = 1,
  parameter int OVC_W  = 1,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FW-1:0]     wr_flit,
  input  logic              pop,
  input  logic              va_gnt,
  input  logic [PORT_W-1:0] va_port,
  input  logic [OVC_W-1:0]  va_ovc,
  output logic [FW-1:0]     front,
  output logic              empty,
  output logic              active,
  output logic [PORT_W-1:0] route,
  output logic [OVC_W-1:0]  ovc
);
  import vcr_pkg::*;

  logic [FW-1:0]     mem [DEPTH];
  logic [AW-1:0]     rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              act_q, act_d;
  logic [PORT_W-1:0] route_q, route_d;
  logic [OVC_W-1:0]  ovc_q, ovc_d;

  always_comb begin
    rd_d    = rd_q;
    wr_d    = wr_q;
    act_d   = act_q;
    route_d = route_q;
    ovc_d   = ovc_q;
    if (pop)   rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    if (wr_en) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    cnt_d = cnt_q + CW'(wr_en) - CW'(pop);
    if (pop && kind_closes(mem[rd_q][FW-1 -: 2])) begin
      act_d = 1'b0;
    end else if (va_gnt) begin
      act_d   = 1'b1;
      route_d = va_port;
      ovc_d   = va_ovc;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= wr_flit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      act_q   <= 1'b0;
      route_q <= '0;
      ovc_q   <= '0;
    end else begin
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      cnt_q   <= cnt_d;
      act_q   <= act_d;
      route_q <= route_d;
      ovc_q   <= ovc_d;
    end
  end

  assign front  = mem[rd_q];
  assign empty  = (cnt_q == '0);
  assign active = act_q;
  assign route  = route_q;
  assign ovc    = ovc_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q != CW'(DEPTH)) || pop);
  assert_pop_front_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty && act_q);
  assert_va_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    va_gnt |-> !act_q && !empty && kind_opens(front[FW-1 -: 2]));
endmodule

// File: rtl/vc_router.sv
module vc_router #(
  parameter int NP    = 2,
  parameter int NV    = 2,
  parameter int DEPTH = 4,
  parameter int CRED  = 4,
  parameter int PW    = 8,
  localparam int PORT_W = (NP > 1) ? $clog2(NP) : 1,
  localparam int OVC_W  = (NV > 1) ? $clog2(NV) : 1,
  localparam int FW     = 2 + PORT_W + PW,
  localparam int NQ     = NP * NV,
  localparam int CW     = $clog2(CRED + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NP-1:0]       in_valid,
  input  logic [NP*OVC_W-1:0] in_vc,
  input  logic [NP*FW-1:0]    in_flit,
  input  logic [NQ-1:0]       credit_ret,
  output logic [NP-1:0]       out_valid,
  output logic [NP*OVC_W-1:0] out_vc,
  output logic [NP*FW-1:0]    out_flit
);
  logic [FW-1:0]     q_front [NQ];
  logic [NQ-1:0]     q_empty, q_active, q_pop, q_vagnt, sa_elig;
  logic [PORT_W-1:0] q_route [NQ];
  logic [OVC_W-1:0]  q_ovc [NQ], q_va_ovc [NQ];
  logic [OVC_W-1:0]  free_idx [NP];
  logic [NP-1:0]     free_any;
  logic [NQ-1:0]     va_req [NP], va_gnt [NP];
  logic [NV-1:0]     in_sel [NP];
  logic [NP-1:0]     sa_win;
  logic [PORT_W-1:0] sel_route [NP];
  logic [OVC_W-1:0]  sel_ovc [NP];
  logic [FW-1:0]     sel_flit [NP];
  logic [NP-1:0]     out_req [NP], out_gnt [NP];
  logic [NP-1:0]     xb_valid;
  logic [FW-1:0]     xb_flit [NP];
  logic [OVC_W-1:0]  xb_vc [NP];
  logic [NQ-1:0]     busy_q, busy_d;
  logic [CW-1:0]     cred_q [NQ], cred_d [NQ];
  logic [NP-1:0]     ov_q;
  logic [FW-1:0]     of_q [NP];
  logic [OVC_W-1:0]  oc_q [NP];

  for (genvar p = 0; p < NP; p++) begin : g_port
    for (genvar v = 0; v < NV; v++) begin : g_vc
      vcr_ivc #(.DEPTH(DEPTH), .FW(FW), .PORT_W(PORT_W), .OVC_W(OVC_W)) u_ivc (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid[p] && (in_vc[p*OVC_W +: OVC_W] == OVC_W'(v))),
        .wr_flit (in_flit[p*FW +: FW]),
        .pop     (q_pop[p*NV+v]),
        .va_gnt  (q_vagnt[p*NV+v]),
        .va_port (q_front[p*NV+v][FW-3 -: PORT_W]),
        .va_ovc  (q_va_ovc[p*NV+v]),
        .front   (q_front[p*NV+v]),
        .empty   (q_empty[p*NV+v]),
        .active  (q_active[p*NV+v]),
        .route   (q_route[p*NV+v]),
        .ovc     (q_ovc[p*NV+v])
      );
    end
    vcr_rr_arb #(.N(NV)) u_sa_in (
      .clk(clk), .rst_n(rst_n), .req(sa_elig[p*NV +: NV]), .adv(sa_win[p]), .gnt(in_sel[p]));
    vcr_rr_arb #(.N(NQ)) u_va (
      .clk(clk), .rst_n(rst_n), .req(va_req[p]), .adv(1'b1), .gnt(va_gnt[p]));
    vcr_rr_arb #(.N(NP)) u_sa_out (
      .clk(clk), .rst_n(rst_n), .req(out_req[p]), .adv(1'b1), .gnt(out_gnt[p]));
    assign out_valid[p]                 = ov_q[p];
    assign out_flit[p*FW +: FW]         = of_q[p];
    assign out_vc[p*OVC_W +: OVC_W]     = oc_q[p];
  end

  // stage 1: route lookup and output-VC allocation
  always_comb begin
    for (int o = 0; o < NP; o++) begin
      free_any[o] = 1'b0;
      free_idx[o] = '0;
      for (int v = NV - 1; v >= 0; v--) begin
        if (!busy_q[o*NV+v]) begin
          free_any[o] = 1'b1;
          free_idx[o] = OVC_W'(v);
        end
      end
      va_req[o] = '0;
      for (int q = 0; q < NQ; q++) begin
        va_req[o][q] = !q_active[q] && !q_empty[q] && q_front[q][FW-1] &&
                       (q_front[q][FW-3 -: PORT_W] == PORT_W'(o)) && free_any[o];
      end
    end
    for (int q = 0; q < NQ; q++) begin
      q_vagnt[q]  = 1'b0;
      q_va_ovc[q] = free_idx[int'(q_front[q][FW-3 -: PORT_W])];
      for (int o = 0; o < NP; o++) q_vagnt[q] = q_vagnt[q] | va_gnt[o][q];
      sa_elig[q] = q_active[q] && !q_empty[q] &&
                   (cred_q[int'(q_route[q])*NV + int'(q_ovc[q])] != '0);
    end
  end

  // stage 2: switch allocation, dequeue, crossbar
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      sel_route[p] = '0;
      sel_ovc[p]   = '0;
      sel_flit[p]  = '0;
      for (int v = 0; v < NV; v++) begin
        if (in_sel[p][v]) begin
          sel_route[p] = q_route[p*NV+v];
          sel_ovc[p]   = q_ovc[p*NV+v];
          sel_flit[p]  = q_front[p*NV+v];
        end
      end
    end
    for (int o = 0; o < NP; o++) begin
      for (int p = 0; p < NP; p++) out_req[o][p] = (|in_sel[p]) && (sel_route[p] == PORT_W'(o));
    end
    sa_win = '0;
    for (int o = 0; o < NP; o++) begin
      xb_valid[o] = |out_gnt[o];
      xb_flit[o]  = '0;
      xb_vc[o]    = '0;
      for (int p = 0; p < NP; p++) begin
        if (out_gnt[o][p]) begin
          sa_win[p]  = 1'b1;
          xb_flit[o] = sel_flit[p];
          xb_vc[o]   = sel_ovc[p];
        end
      end
    end
    for (int q = 0; q < NQ; q++) q_pop[q] = in_sel[q / NV][q % NV] && sa_win[q / NV];
  end

  // output-VC ownership and credit bookkeeping
  always_comb begin
    busy_d = busy_q;
    for (int k = 0; k < NQ; k++) cred_d[k] = cred_q[k] + CW'(credit_ret[k]);
    for (int o = 0; o < NP; o++) begin
      if (|va_gnt[o]) busy_d[o*NV + int'(free_idx[o])] = 1'b1;
      if (xb_valid[o]) begin
        cred_d[o*NV + int'(xb_vc[o])] = cred_d[o*NV + int'(xb_vc[o])] - CW'(1);
        if (xb_flit[o][FW-2]) busy_d[o*NV + int'(xb_vc[o])] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      ov_q   <= '0;
      for (int k = 0; k < NQ; k++) cred_q[k] <= CW'(CRED);
      for (int o = 0; o < NP; o++) begin
        of_q[o] <= '0;
        oc_q[o] <= '0;
      end
    end else begin
      busy_q <= busy_d;
      ov_q   <= xb_valid;
      for (int k = 0; k < NQ; k++) cred_q[k] <= cred_d[k];
      for (int o = 0; o < NP; o++) begin
        if (xb_valid[o]) begin
          of_q[o] <= xb_flit[o];
          oc_q[o] <= xb_vc[o];
        end
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_chk_out
    assert_credit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      xb_valid[o] |-> cred_q[o*NV + int'(xb_vc[o])] != '0);
    assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (xb_valid[o] && xb_flit[o][FW-2]) |=> !busy_q[o*NV + int'($past(xb_vc[o]))]);
    assert_one_per_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(q_pop[o*NV +: NV]));
  end
  for (genvar k = 0; k < NQ; k++) begin : g_chk_cred
    assert_credit_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
      credit_ret[k] |-> cred_q[k] != CW'(CRED));
  end
endmodule

// File: tb/vc_router_tb.sv
module vc_router_tb;
  localparam int FW = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  in_valid = '0;
  logic [1:0]  in_vc = '0;
  logic [21:0] in_flit = '0;
  logic [3:0]  credit_ret;
  logic [3:0]  auto_mask = '0;
  logic [3:0]  man_ret = '0;
  logic        auto_on = 1'b1;
  logic [1:0]  out_valid;
  logic [1:0]  out_vc;
  logic [21:0] out_flit;

  int checks = 0, failures = 0, cyc = 0;
  int log_n [2];
  int log_t [2][64];
  int log_v [2][64];
  logic [FW-1:0] log_f [2][64];

  assign credit_ret = auto_mask | man_ret;

  vc_router u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_flit(in_flit),
    .credit_ret(credit_ret), .out_valid(out_valid), .out_vc(out_vc), .out_flit(out_flit));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic [3:0] m;
    m = '0;
    for (int o = 0; o < 2; o++) begin
      if (out_valid[o]) begin
        if (log_n[o] < 64) begin
          log_t[o][log_n[o]] = cyc;
          log_v[o][log_n[o]] = int'(out_vc[o]);
          log_f[o][log_n[o]] = out_flit[o*FW +: FW];
          log_n[o]++;
        end
        m[o*2 + int'(out_vc[o])] = 1'b1;
      end
    end
    auto_mask = auto_on ? m : '0;
  end

  function automatic logic [FW-1:0] mkf(logic [1:0] k, int d, int pay);
    return {k, d[0], pay[7:0]};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find(int o, int pay);
    for (int i = 0; i < log_n[o]; i++) if (int'(log_f[o][i][7:0]) == pay) return i;
    return -1;
  endfunction

  function automatic int tof(int o, int pay);
    int i = find(o, pay);
    return (i < 0) ? -1 : log_t[o][i];
  endfunction

  function automatic int vof(int o, int pay);
    int i = find(o, pay);
    return (i < 0) ? -1 : log_v[o][i];
  endfunction

  task automatic clear_log();
    log_n[0] = 0;
    log_n[1] = 0;
  endtask

  task automatic send_flit(int p, int v, logic [FW-1:0] f);
    in_valid[p] = 1'b1;
    in_vc[p] = v[0];
    in_flit[p*FW +: FW] = f;
    @(negedge clk);
    in_valid[p] = 1'b0;
  endtask

  task automatic settle();
    repeat (15) @(negedge clk);
  endtask

  task automatic test_reset();
    for (int i = 0; i < 3; i++) begin
      check(out_valid == 2'b00, "R1 idle output after reset", int'(out_valid), 0);
      @(negedge clk);
    end
  endtask

  task automatic test_latency();
    int s;
    clear_log();
    s = cyc;
    send_flit(0, 0, mkf(2'b10, 1, 8'h10));
    send_flit(0, 0, mkf(2'b00, 1, 8'h11));
    send_flit(0, 0, mkf(2'b01, 1, 8'h12));
    send_flit(0, 0, mkf(2'b10, 1, 8'h20));
    send_flit(0, 0, mkf(2'b01, 1, 8'h21));
    settle();
    check(tof(1, 8'h10) == s + 3, "R2 head latency to port 1", tof(1, 8'h10), s + 3);
    check(tof(1, 8'h11) == s + 4, "R3 body follows head", tof(1, 8'h11), s + 4);
    check(tof(1, 8'h12) == s + 5, "R3 tail follows body", tof(1, 8'h12), s + 5);
    check(vof(1, 8'h11) == vof(1, 8'h10) && vof(1, 8'h12) == vof(1, 8'h10),
          "R4 same output VC", vof(1, 8'h12), vof(1, 8'h10));
    check(tof(1, 8'h20) == tof(1, 8'h12) + 2, "R5 bubble before next head",
          tof(1, 8'h20), tof(1, 8'h12) + 2);
    check(tof(1, 8'h21) == tof(1, 8'h20) + 1, "R3 second packet tail", tof(1, 8'h21), tof(1, 8'h20) + 1);
    check(log_n[0] == 0, "R2 nothing on port 0", log_n[0], 0);
  endtask

  task automatic test_interleave();
    clear_log();
    send_flit(0, 0, mkf(2'b10, 1, 8'h30));
    send_flit(0, 1, mkf(2'b10, 1, 8'h40));
    send_flit(0, 0, mkf(2'b00, 1, 8'h31));
    send_flit(0, 1, mkf(2'b00, 1, 8'h41));
    send_flit(0, 0, mkf(2'b01, 1, 8'h32));
    send_flit(0, 1, mkf(2'b01, 1, 8'h42));
    settle();
    check(log_n[1] == 6, "R6 both packets delivered", log_n[1], 6);
    check(tof(1, 8'h40) >= 0 && tof(1, 8'h40) < tof(1, 8'h32), "R6 second VC head before first tail",
          tof(1, 8'h40), tof(1, 8'h32));
    check(vof(1, 8'h30) != vof(1, 8'h40), "R6 distinct output VCs", vof(1, 8'h40), 1 - vof(1, 8'h30));
    check(tof(1, 8'h30) < tof(1, 8'h31) && tof(1, 8'h31) < tof(1, 8'h32) &&
          tof(1, 8'h40) < tof(1, 8'h41) && tof(1, 8'h41) < tof(1, 8'h42),
          "R3 order within each packet", tof(1, 8'h42), tof(1, 8'h41) + 1);
    check(vof(1, 8'h42) == vof(1, 8'h40), "R4 tail keeps its VC", vof(1, 8'h42), vof(1, 8'h40));
  endtask

  task automatic test_single();
    int s;
    clear_log();
    s = cyc;
    send_flit(1, 1, mkf(2'b11, 0, 8'h50));
    send_flit(1, 1, mkf(2'b11, 0, 8'h51));
    settle();
    check(vof(0, 8'h50) == 0, "R7 input VC 1 gets output VC 0", vof(0, 8'h50), 0);
    check(tof(0, 8'h50) == s + 3, "R11 single-flit latency", tof(0, 8'h50), s + 3);
    check(vof(0, 8'h51) == 0, "R11 released VC reused", vof(0, 8'h51), 0);
    check(tof(0, 8'h51) == tof(0, 8'h50) + 2, "R11 bubble after single", tof(0, 8'h51), tof(0, 8'h50) + 2);
  endtask

  task automatic test_no_free_vc();
    int open, mx;
    clear_log();
    fork
      begin
        send_flit(0, 0, mkf(2'b10, 0, 8'h60));
        send_flit(0, 1, mkf(2'b10, 0, 8'h70));
        send_flit(0, 0, mkf(2'b00, 0, 8'h61));
        send_flit(0, 1, mkf(2'b00, 0, 8'h71));
        send_flit(0, 0, mkf(2'b01, 0, 8'h62));
        send_flit(0, 1, mkf(2'b01, 0, 8'h72));
      end
      begin
        send_flit(1, 0, mkf(2'b10, 0, 8'h80));
        send_flit(1, 0, mkf(2'b01, 0, 8'h81));
      end
    join
    settle();
    check(log_n[0] == 8, "R8 all flits delivered", log_n[0], 8);
    open = 0;
    mx = 0;
    for (int i = 0; i < log_n[0]; i++) begin
      if (log_f[0][i][10]) open++;
      if (open > mx) mx = open;
      if (log_f[0][i][9]) open--;
    end
    check(mx == 2, "R8 at most two open packets", mx, 2);
    check(tof(0, 8'h81) == tof(0, 8'h80) + 1 || tof(0, 8'h81) > tof(0, 8'h80),
          "R4 blocked packet in order", tof(0, 8'h81), tof(0, 8'h80) + 1);
  endtask

  task automatic test_credit();
    int k, vc;
    clear_log();
    auto_on = 1'b0;
    send_flit(1, 0, mkf(2'b10, 0, 8'h90));
    for (int i = 1; i < 5; i++) send_flit(1, 0, mkf(2'b00, 0, 8'h90 + i));
    send_flit(1, 0, mkf(2'b01, 0, 8'h95));
    settle();
    check(log_n[0] == 4, "R9 stalls at zero credits", log_n[0], 4);
    vc = vof(0, 8'h90);
    k = cyc;
    man_ret[vc] = 1'b1;
    @(negedge clk);
    man_ret = '0;
    repeat (6) @(negedge clk);
    check(tof(0, 8'h94) == k + 2, "R9 credit return timing", tof(0, 8'h94), k + 2);
    check(log_n[0] == 5, "R9 one credit one flit", log_n[0], 5);
    k = cyc;
    man_ret[vc] = 1'b1;
    @(negedge clk);
    man_ret = '0;
    repeat (6) @(negedge clk);
    check(tof(0, 8'h95) == k + 2, "R9 tail after second credit", tof(0, 8'h95), k + 2);
    for (int i = 0; i < 4; i++) begin
      man_ret[vc] = 1'b1;
      @(negedge clk);
    end
    man_ret = '0;
    auto_on = 1'b1;
    settle();
  endtask

  task automatic test_conflict();
    clear_log();
    fork
      begin
        send_flit(0, 0, mkf(2'b10, 0, 8'hA0));
        send_flit(0, 0, mkf(2'b00, 0, 8'hA1));
        send_flit(0, 0, mkf(2'b01, 0, 8'hA2));
      end
      begin
        send_flit(1, 0, mkf(2'b10, 0, 8'hB0));
        send_flit(1, 0, mkf(2'b00, 0, 8'hB1));
        send_flit(1, 0, mkf(2'b01, 0, 8'hB2));
      end
    join
    settle();
    check(log_n[0] == 6, "R10 six flits on port 0", log_n[0], 6);
    check(log_t[0][5] - log_t[0][0] >= 5, "R10 one flit per output per cycle",
          log_t[0][5] - log_t[0][0], 5);
    check(tof(0, 8'hA2) > tof(0, 8'hA1) && tof(0, 8'hB2) > tof(0, 8'hB1),
          "R3 order under contention", tof(0, 8'hB2), tof(0, 8'hB1) + 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    log_n[0] = 0;
    log_n[1] = 0;
    repeat (3) @(negedge clk);
    check(out_valid == 2'b00, "R1 reset output", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_latency();
    test_interleave();
    test_single();
    test_no_free_vc();
    test_credit();
    test_conflict();
    test_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule